// File: doc/BRIEF.md
# Split-Mode Performance Counter Unit

This block is a register-mapped event counter bank. It holds four physical counters, each able to run either as one 32-bit count or as a pair of independent 16-bit counts. This gives up to eight logical counters. Each logical counter has its own event input. While the unit is enabled, a counter advances by one on every clock where its event input is high. When any count wraps past its maximum, a per-logical-counter status flag is raised. The interrupt line is the OR of those flags that are also set in a software-loaded enable mask.

Software writes to a counter do not touch the running count. The value is parked in a holding latch for that physical counter. A later write of the control register with its enable bit set moves every parked value into its live counter in a single clock. The status register is cleared by reading it. Writing the status address loads the interrupt mask instead. Every register is 32 bits wide and sits in the upper half of a 64-bit bus word.

Top module: `perf_split_counters`

## Requirements
- R1: After a synchronous reset, all counts, latches, control, status, mask, read data and the interrupt output are zero.
- R2: Register data travels in bus bits 63:32. Bits 31:0 are ignored on write and always read as zero. Word addresses 0 to 7 select logical counters, 8 selects control and 9 selects status. Control bit 0 is the enable, and control bit 4+p puts physical counter p into 16-bit mode.
- R3: A write to a counter address loads only the holding latch of physical counter (address mod 4) and marks it pending. The live count is not changed.
- R4: A control write with bit 0 set copies every pending latch into its live counter in that cycle and clears all pending marks. This also happens when the unit is already enabled. A control write with bit 0 clear leaves the latches pending.
- R5: A counter read returns the live value, or the latch value when that counter is pending and the unit is disabled. In 16-bit mode, addresses 0 to 3 return the upper half and addresses 4 to 7 return the lower half, zero-extended. In 32-bit mode, both addresses return the full value.
- R6: In 16-bit mode, a counter write replaces only its own half of the latch. The other half is taken from the latch if pending, otherwise from the live count.
- R7: While enabled, a 32-bit counter p adds one per cycle of event p. In 16-bit mode the upper half follows event p, the lower half follows event p+4, and neither carries into the other. While disabled, counts hold. A counter being committed loads its latch instead of counting.
- R8: A wrap from all ones to zero sets status bit p for a 32-bit counter or an upper half, and status bit p+4 for a lower half.
- R9: A status read returns the flags in bits 39:32 and clears them. A wrap in the same cycle as the read remains set afterwards.
- R10: A status write loads the mask from bits 39:32. The interrupt output equals the OR of status AND mask, updated at the same clock edge as the status register.
- R11: Read data is registered. It appears after the clock edge that takes the read and holds until the next read. Addresses 10 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 64 | Write data, register in bits 63:32 |
| bus_rdata | output | 64 | Registered read data, register in bits 63:32 |
| evt | input | 8 | Event inputs, one per logical counter |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The hardest situation to create from the ports is a wrap that lands in the same clock as a status read. It needs a preloaded count, a committing control write and an event pulse timed to that one read cycle. The bench reaches it directly by committing a value of all ones and raising the event together with the read. The random phase favours preload values a few counts below both the 16-bit and 32-bit limits, so that wraps, mode switches and writes of the other half happen often and in many orders.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int BUS_W       = 64;
  localparam int REG_W       = 32;
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_SPLIT0 = 4;

  typedef struct packed {
    logic full;
    logic hi;
    logic lo;
  } ctr_wr_t;
endpackage

// File: rtl/pcu_slice.sv
module pcu_slice
  import pcu_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          split,
  input  logic          commit,
  input  logic          ev_hi,
  input  logic          ev_lo,
  input  ctr_wr_t       wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] live,
  output logic [CW-1:0] latch,
  output logic          pending,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;

  logic [CW-1:0] base;
  logic          take;

  assign base = pending ? latch : live;
  assign take = commit & pending;

  always_comb begin
    ovf_hi = 1'b0;
    ovf_lo = 1'b0;
    if (en && !take) begin
      if (split) begin
        ovf_hi = ev_hi && (live[CW-1:HW] == '1);
        ovf_lo = ev_lo && (live[HW-1:0] == '1);
      end else begin
        ovf_hi = ev_hi && (live == '1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      latch   <= '0;
      pending <= 1'b0;
    end else begin
      if (wr.full) begin
        latch   <= wdata;
        pending <= 1'b1;
      end else if (wr.hi) begin
        latch   <= {wdata[HW-1:0], base[HW-1:0]};
        pending <= 1'b1;
      end else if (wr.lo) begin
        latch   <= {base[CW-1:HW], wdata[HW-1:0]};
        pending <= 1'b1;
      end else if (take) begin
        pending <= 1'b0;
      end

      if (take) begin
        live <= latch;
      end else if (en) begin
        if (split) begin
          live[CW-1:HW] <= live[CW-1:HW] + HW'(ev_hi);
          live[HW-1:0]  <= live[HW-1:0] + HW'(ev_lo);
        end else begin
          live <= live + CW'(ev_hi);
        end
      end
    end
  end
endmodule

// File: rtl/pcu_status.sv
module pcu_status #(
  parameter int NLOG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLOG-1:0] ovf,
  input  logic            rd_clr,
  input  logic            mask_wr,
  input  logic [NLOG-1:0] mask_in,
  output logic [NLOG-1:0] status_q,
  output logic [NLOG-1:0] mask_q,
  output logic            irq
);
  logic [NLOG-1:0] status_d;
  logic [NLOG-1:0] mask_d;

  assign status_d = (rd_clr ? '0 : status_q) | ovf;
  assign mask_d   = mask_wr ? mask_in : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq      <= |(status_d & mask_d);
    end
  end
endmodule

// File: rtl/perf_split_counters.sv
module perf_split_counters
  import pcu_pkg::*;
#(
  parameter int NPHYS = 4,
  parameter int CW    = 32,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [2*NPHYS-1:0] evt,
  output logic               irq
);
  localparam int NLOG      = 2 * NPHYS;
  localparam int HW        = CW / 2;
  localparam int PW        = $clog2(NPHYS);
  localparam int ADDR_CTRL = NLOG;
  localparam int ADDR_STAT = NLOG + 1;

  logic [REG_W-1:0]    wreg;
  logic [REG_W-1:0]    ctrl_q;
  logic                en_q;
  logic                ctrl_wr;
  logic                commit;
  logic                ctr_wr;
  logic                stat_rd;
  logic                stat_wr;
  logic [CW-1:0]       live_a  [NPHYS];
  logic [CW-1:0]       latch_a [NPHYS];
  logic [NPHYS-1:0]    pend_vec;
  logic [NPHYS*CW-1:0] live_flat;
  logic [NLOG-1:0]     ovf_vec;
  logic [NLOG-1:0]     status_q;
  logic [NLOG-1:0]     mask_q;
  logic [REG_W-1:0]    rd_val;
  logic [PW-1:0]       rd_p;
  logic [CW-1:0]       rd_raw;

  assign wreg    = bus_wdata[BUS_W-1:REG_W];
  assign en_q    = ctrl_q[CTRL_EN_BIT];
  assign ctrl_wr = bus_wr && (int'(bus_addr) == ADDR_CTRL);
  assign commit  = ctrl_wr && wreg[CTRL_EN_BIT];
  assign ctr_wr  = bus_wr && (int'(bus_addr) < NLOG);
  assign stat_rd = bus_rd && (int'(bus_addr) == ADDR_STAT);
  assign stat_wr = bus_wr && (int'(bus_addr) == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wreg;
    end
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_ctr
    logic    sel_up;
    logic    sel_dn;
    logic    split;
    ctr_wr_t wr;

    assign split   = ctrl_q[CTRL_SPLIT0 + p];
    assign sel_up  = ctr_wr && (int'(bus_addr) == p);
    assign sel_dn  = ctr_wr && (int'(bus_addr) == p + NPHYS);
    assign wr.full = (sel_up || sel_dn) && !split;
    assign wr.hi   = sel_up && split;
    assign wr.lo   = sel_dn && split;

    pcu_slice #(.CW(CW)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .en      (en_q),
      .split   (split),
      .commit  (commit),
      .ev_hi   (evt[p]),
      .ev_lo   (evt[p + NPHYS]),
      .wr      (wr),
      .wdata   (wreg[CW-1:0]),
      .live    (live_a[p]),
      .latch   (latch_a[p]),
      .pending (pend_vec[p]),
      .ovf_hi  (ovf_vec[p]),
      .ovf_lo  (ovf_vec[p + NPHYS])
    );

    assign live_flat[p*CW +: CW] = live_a[p];
  end

  pcu_status #(.NLOG(NLOG)) u_status (
    .clk      (clk),
    .rst      (rst),
    .ovf      (ovf_vec),
    .rd_clr   (stat_rd),
    .mask_wr  (stat_wr),
    .mask_in  (wreg[NLOG-1:0]),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  assign rd_p   = bus_addr[PW-1:0];
  assign rd_raw = (pend_vec[rd_p] && !en_q) ? latch_a[rd_p] : live_a[rd_p];

  always_comb begin
    rd_val = '0;
    if (int'(bus_addr) < NLOG) begin
      if (ctrl_q[CTRL_SPLIT0 + int'(rd_p)]) begin
        rd_val = (int'(bus_addr) < NPHYS) ? REG_W'(rd_raw[CW-1:HW])
                                          : REG_W'(rd_raw[HW-1:0]);
      end else begin
        rd_val = REG_W'(rd_raw);
      end
    end else if (int'(bus_addr) == ADDR_CTRL) begin
      rd_val = ctrl_q;
    end else if (int'(bus_addr) == ADDR_STAT) begin
      rd_val = REG_W'(status_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= {rd_val, {(BUS_W-REG_W){1'b0}}};
    end
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
  import pcu_pkg::*;
#(
  parameter int NPHYS = 4,
  parameter int CW    = 32,
  parameter int AW    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [AW-1:0]        bus_addr,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic                 irq,
  input logic                 en_q,
  input logic [NPHYS-1:0]     pend_vec,
  input logic [NPHYS*CW-1:0]  live_flat,
  input logic [2*NPHYS-1:0]   status_q,
  input logic [2*NPHYS-1:0]   mask_q,
  input logic [2*NPHYS-1:0]   ovf_vec
);
  localparam int NLOG      = 2 * NPHYS;
  localparam int ADDR_CTRL = NLOG;
  localparam int ADDR_STAT = NLOG + 1;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (status_q == '0 && !irq && !en_q && bus_rdata == '0)); // R1

  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1:0] == '0); // R2

  AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) < NLOG && !en_q) |=> $stable(live_flat)); // R3

  AST_COMMIT_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == ADDR_CTRL && bus_wdata[REG_W + CTRL_EN_BIT])
      |=> (pend_vec == '0)); // R4

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !(bus_wr && int'(bus_addr) == ADDR_CTRL)) |=> $stable(live_flat)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) == ADDR_STAT && ovf_vec == '0) |=> (status_q == '0)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq == |(status_q & mask_q)); // R10
endmodule

bind perf_split_counters pcu_checker #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .en_q      (en_q),
  .pend_vec  (pend_vec),
  .live_flat (live_flat),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .ovf_vec   (ovf_vec)
);

// File: tb/perf_split_counters_bench.sv
module perf_split_counters_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  evt = '0;
  logic        irq;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;

  logic [31:0] m_live  [4];
  logic [31:0] m_latch [4];
  logic [3:0]  m_pend;
  logic [31:0] m_ctrl;
  logic [7:0]  m_status;
  logic [7:0]  m_mask;
  logic [63:0] m_rdata;

  always #2.5 clk = ~clk;

  perf_split_counters u_perf_split_counters (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (evt),
    .irq       (irq)
  );

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] raw;
    int p;
    if (a < 8) begin
      p   = a % 4;
      raw = (m_pend[p] && !m_ctrl[0]) ? m_latch[p] : m_live[p];
      if (m_ctrl[4+p]) return (a < 4) ? {16'h0, raw[31:16]} : {16'h0, raw[15:0]};
      return raw;
    end
    if (a == 8) return m_ctrl;
    if (a == 9) return {24'h0, m_status};
    return 32'h0;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 8) return "R5";
    if (a == 8) return "R2";
    if (a == 9) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic wr, input logic rd, input int a,
                            input logic [63:0] wd, input logic [7:0] ev);
    logic [31:0] w;
    logic        en;
    logic        cm;
    logic [7:0]  ovf;
    logic [31:0] base;
    logic        take;
    logic [31:0] nlive  [4];
    logic [31:0] nlatch [4];
    logic [3:0]  npend;
    w   = wd[63:32];
    en  = m_ctrl[0];
    cm  = wr && a == 8 && w[0];
    ovf = '0;
    if (rd) m_rdata = {exp_read(a), 32'h0};
    npend = m_pend;
    for (int p = 0; p < 4; p++) begin
      nlive[p]  = m_live[p];
      nlatch[p] = m_latch[p];
      take = cm && m_pend[p];
      base = m_pend[p] ? m_latch[p] : m_live[p];
      if (wr && (a == p || a == p + 4)) begin
        if (!m_ctrl[4+p]) nlatch[p] = w;
        else if (a == p) nlatch[p] = {w[15:0], base[15:0]};
        else nlatch[p] = {base[31:16], w[15:0]};
        npend[p] = 1'b1;
      end else if (take) begin
        npend[p] = 1'b0;
      end
      if (take) begin
        nlive[p] = m_latch[p];
      end else if (en) begin
        if (m_ctrl[4+p]) begin
          ovf[p]   = ev[p] && m_live[p][31:16] == 16'hFFFF;
          ovf[p+4] = ev[p+4] && m_live[p][15:0] == 16'hFFFF;
          nlive[p][31:16] = m_live[p][31:16] + 16'(ev[p]);
          nlive[p][15:0]  = m_live[p][15:0] + 16'(ev[p+4]);
        end else begin
          ovf[p]   = ev[p] && m_live[p] == 32'hFFFFFFFF;
          nlive[p] = m_live[p] + 32'(ev[p]);
        end
      end
    end
    m_status = ((rd && a == 9) ? 8'h0 : m_status) | ovf;
    if (wr && a == 9) m_mask = w[7:0];
    if (wr && a == 8) m_ctrl = w;
    for (int p = 0; p < 4; p++) begin
      m_live[p]  = nlive[p];
      m_latch[p] = nlatch[p];
    end
    m_pend = npend;
  endtask

  task automatic step(input logic wr, input logic rd, input int a,
                      input logic [31:0] wv, input logic [7:0] ev, input string tag);
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = 4'(a);
    bus_wdata = {wv, $urandom()};
    evt       = ev;
    @(posedge clk);
    model_step(wr, rd, a, bus_wdata, ev);
    #1;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    evt    = '0;
    if (rd) check(tag, bus_rdata, m_rdata);
    check("R10", {63'h0, irq}, {63'h0, |(m_status & m_mask)});
  endtask

  task automatic wr_reg(input int a, input logic [31:0] v, input string tag);
    step(1'b1, 1'b0, a, v, 8'h0, tag);
  endtask

  task automatic rd_reg(input int a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, 8'h0, tag);
  endtask

  function automatic logic [31:0] near_wrap();
    case ($urandom_range(0, 3))
      0: return 32'hFFFFFFFF - 32'($urandom_range(0, 6));
      1: return 32'h0000FFFF - 32'($urandom_range(0, 6));
      2: return {16'hFFFF - 16'($urandom_range(0, 4)), 16'hFFFF - 16'($urandom_range(0, 4))};
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) begin
      m_live[p]  = '0;
      m_latch[p] = '0;
    end
    m_pend = '0; m_ctrl = '0; m_status = '0; m_mask = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1", bus_rdata, 64'h0);
    check("R1", {63'h0, irq}, 64'h0);
    rd_reg(9, "R1");
    rd_reg(0, "R1");

    // R3 write parks in latch, read while disabled shows latch
    wr_reg(0, 32'h12345678, "R3");
    rd_reg(0, "R3");
    wr_reg(8, 32'h0, "R4");
    rd_reg(0, "R4");
    wr_reg(8, 32'h1, "R4");
    rd_reg(0, "R4");
    wr_reg(1, 32'hCAFE0000, "R3");
    rd_reg(1, "R3");
    wr_reg(8, 32'h1, "R4");
    rd_reg(1, "R4");
    rd_reg(2, "R2");

    // R6 split halves merge
    wr_reg(8, 32'h10, "R6");
    wr_reg(0, 32'h0000AAAA, "R6");
    wr_reg(4, 32'h0000BBBB, "R6");
    rd_reg(0, "R6");
    rd_reg(4, "R6");
    wr_reg(8, 32'h00, "R6");
    rd_reg(0, "R6");
    rd_reg(4, "R6");

    // R7 R8 no carry across halves, lower half wraps
    wr_reg(8, 32'h10, "R7");
    wr_reg(4, 32'h0000FFFE, "R7");
    wr_reg(0, 32'h00000000, "R7");
    wr_reg(9, 32'h10, "R10");
    wr_reg(8, 32'h11, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 32'h0, 8'h10, "R7");
    rd_reg(0, "R7");
    rd_reg(4, "R8");
    rd_reg(9, "R9");
    rd_reg(9, "R9");

    // R8 32-bit wrap on counter 2, R9 wrap during status read on counter 3
    wr_reg(2, 32'hFFFFFFFF, "R8");
    wr_reg(3, 32'hFFFFFFFF, "R9");
    wr_reg(8, 32'h01, "R4");
    step(1'b0, 1'b0, 0, 32'h0, 8'h04, "R8");
    step(1'b0, 1'b1, 9, 32'h0, 8'h08, "R9");
    rd_reg(9, "R9");
    rd_reg(2, "R8");
    rd_reg(12, "R11");
    wr_reg(9, 32'h0, "R10");

    for (int i = 0; i < 4000; i++) begin
      int a;
      int op;
      logic [31:0] v;
      a  = ($urandom_range(0, 19) == 0) ? $urandom_range(10, 15) : $urandom_range(0, 9);
      op = $urandom_range(0, 9);
      if (a < 8) v = near_wrap();
      else if (a == 8) v = {24'h0, 4'($urandom()), 3'h0, 1'($urandom_range(0, 9) < 7)};
      else v = $urandom();
      if (op < 3) step(1'b1, 1'b0, a, v, 8'($urandom()), tag_of(a));
      else if (op < 6) step(1'b0, 1'b1, a, 32'h0, 8'($urandom()), tag_of(a));
      else step(1'b0, 1'b0, a, 32'h0, 8'($urandom()), "R7");
    end
    for (int a = 0; a < 10; a++) rd_reg(a, tag_of(a));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule